// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block holds the program counter of a 32-bit RISC core whose instructions are all four bytes wide. On each cycle in which an instruction is presented as valid, it decodes the control-flow part of the instruction word and loads the PC with the address of the next instruction in a single step. The next address can come from several places:

- sequential flow;
- a PC-relative branch, conditional or unconditional;
- an absolute jump within the current 256 MB region;
- a register operand;
- the return-address value;
- the exception-return or break-return value.

Register operands come in already read by the surrounding pipeline. The block does not hold them.

Some instructions also produce a register write: a call writes its return address, and the next-PC capture writes the sequential address. That write is given out as a request on the link port, in the same cycle as the instruction. The two return-from-handler instructions also raise a one-cycle request to restore the status word. A redirect input, driven by exception entry logic outside the block, takes priority over everything else. It loads its vector into the PC and cancels the side effects of the instruction presented in that cycle.

Internally the instruction is sorted into one of eleven flow classes:

| Class | Instructions |
|---|---|
| SEQ | any opcode without control flow |
| BR | unconditional branch |
| BCOND | the six conditional branches |
| JABS | absolute jump |
| CALL | absolute call |
| JREG | register jump |
| CALLR | register call |
| RET | return |
| NEXTPC | next-PC capture |
| ERET | exception return |
| BRET | break return |

The PC register moves between its values along three transitions:

- **RESET**: load `RESET_PC`.
- **REDIRECT**: load the redirect vector.
- **ADVANCE**: load the class target.

With neither a valid instruction nor a redirect, it HOLDs.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, the PC is set to the parameter `RESET_PC`. With no valid instruction and no redirect, `link_we` and `status_restore` are 0.
- R2: The PC holds its value in a cycle without `instr_valid` or `redirect_valid`. A valid instruction whose opcode (bits [5:0]) has no control-flow meaning advances the PC to PC+4 at the next clock edge.
- R3: Opcode 0x06 loads PC+4 plus the sign-extended 16-bit field at bits [21:6], with that field's two low bits forced to zero.
- R4: Conditional branches compare operand A (from register field bits [31:27]) with operand B (field bits [26:22]). They use the R3 target when taken and PC+4 otherwise. The conditions are: 0x0E signed A>=B, 0x16 signed A<B, 0x1E A!=B, 0x26 A==B, 0x2E unsigned A>=B, 0x36 unsigned A<B.
- R5: Opcode 0x01 loads {PC[31:28], bits[31:6], 2'b00}. Opcode 0x00 loads the same address and requests a link write of PC+4 to register 31.
- R6: The register-form opcode is 0x3A, with the extended code in bits [16:11]. Extended code 0x0D loads operand A. Code 0x1D loads operand A and requests a link write of PC+4 to register 31. Code 0x05 loads `ra_val`.
- R7: Extended code 0x1C requests a link write of PC+4 to the register named by bits [21:17]. The request is suppressed when that field is 0.
- R8: Extended code 0x01 loads `ea_val` and code 0x09 loads `ba_val`. Both assert `status_restore` in the same cycle as the instruction.
- R9: `redirect_valid` loads `redirect_pc` at the next edge regardless of `instr_valid`. In that cycle it forces `link_we` and `status_restore` to 0.
- R10: The link request is combinational. `link_we`, `link_addr` and `link_data` are valid in the same cycle as `instr_valid`, and `link_data` is always PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | Value of the register named in field A |
| opnd_b | input | 32 | Value of the register named in field B |
| ra_val | input | 32 | Value of return-address register 31 |
| ea_val | input | 32 | Value of exception-return register 29 |
| ba_val | input | 32 | Value of break-return register 30 |
| redirect_valid | input | 1 | Exception redirect request |
| redirect_pc | input | 32 | Redirect vector |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Register write request |
| link_addr | output | 5 | Destination register of the write |
| link_data | output | 32 | Data of the write (PC+4) |
| status_restore | output | 1 | Request to restore the status word |

## Verification
The only state is the PC. A wrong PC value shows up at the `pc` port one clock after the instruction that produced it. From then on it also corrupts `link_data` combinationally, because every later target is computed from it. A wrong flow class for an instruction shows up in the same cycle as a wrong link request or restore pulse. It shows up at the next edge as a PC that misses the model's target. The bench therefore compares `pc` after every edge, and the link and restore outputs in every cycle, against an independent model.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN  = 32;
    localparam int IDX_W = 5;

    // primary opcodes, bits [5:0]
    localparam logic [5:0] OPC_CALL  = 6'h00;
    localparam logic [5:0] OPC_JABS  = 6'h01;
    localparam logic [5:0] OPC_BR    = 6'h06;
    localparam logic [5:0] OPC_BGE   = 6'h0E;
    localparam logic [5:0] OPC_BLT   = 6'h16;
    localparam logic [5:0] OPC_BNE   = 6'h1E;
    localparam logic [5:0] OPC_BEQ   = 6'h26;
    localparam logic [5:0] OPC_BGEU  = 6'h2E;
    localparam logic [5:0] OPC_BLTU  = 6'h36;
    localparam logic [5:0] OPC_REG   = 6'h3A;

    // extended codes of the register form, bits [16:11]
    localparam logic [5:0] XC_ERET   = 6'h01;
    localparam logic [5:0] XC_RET    = 6'h05;
    localparam logic [5:0] XC_BRET   = 6'h09;
    localparam logic [5:0] XC_JREG   = 6'h0D;
    localparam logic [5:0] XC_NEXTPC = 6'h1C;
    localparam logic [5:0] XC_CALLR  = 6'h1D;

    typedef enum logic [3:0] {
        FL_SEQ, FL_BR, FL_BCOND, FL_JABS, FL_CALL, FL_JREG,
        FL_CALLR, FL_RET, FL_NEXTPC, FL_ERET, FL_BRET
    } flow_e;

    typedef enum logic [2:0] {
        CMP_GE, CMP_LT, CMP_NE, CMP_EQ, CMP_GEU, CMP_LTU
    } cmp_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] xcode,
    output flow_e      flow,
    output cmp_e       cond
);

    always_comb begin
        flow = FL_SEQ;
        cond = CMP_EQ;
        unique case (op)
            OPC_CALL: flow = FL_CALL;
            OPC_JABS: flow = FL_JABS;
            OPC_BR:   flow = FL_BR;
            OPC_BGE:  begin flow = FL_BCOND; cond = CMP_GE;  end
            OPC_BLT:  begin flow = FL_BCOND; cond = CMP_LT;  end
            OPC_BNE:  begin flow = FL_BCOND; cond = CMP_NE;  end
            OPC_BEQ:  begin flow = FL_BCOND; cond = CMP_EQ;  end
            OPC_BGEU: begin flow = FL_BCOND; cond = CMP_GEU; end
            OPC_BLTU: begin flow = FL_BCOND; cond = CMP_LTU; end
            OPC_REG: begin
                unique case (xcode)
                    XC_ERET:   flow = FL_ERET;
                    XC_RET:    flow = FL_RET;
                    XC_BRET:   flow = FL_BRET;
                    XC_JREG:   flow = FL_JREG;
                    XC_NEXTPC: flow = FL_NEXTPC;
                    XC_CALLR:  flow = FL_CALLR;
                    default:   flow = FL_SEQ;
                endcase
            end
            default: flow = FL_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_compare.sv
module npc_compare
    import npc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  cmp_e         cond,
    output logic         taken
);

    always_comb begin
        unique case (cond)
            CMP_GE:  taken = $signed(opnd_a) >= $signed(opnd_b);
            CMP_LT:  taken = $signed(opnd_a) <  $signed(opnd_b);
            CMP_NE:  taken = opnd_a != opnd_b;
            CMP_EQ:  taken = opnd_a == opnd_b;
            CMP_GEU: taken = opnd_a >= opnd_b;
            CMP_LTU: taken = opnd_a <  opnd_b;
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int W        = 32,
    parameter int IW       = 5,
    parameter int LINK_IDX = 31
) (
    input  flow_e         flow,
    input  logic          taken,
    input  logic [W-1:0]  pc,
    input  logic [25:0]   imm26,
    input  logic [IW-1:0] c_idx,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  ra_val,
    input  logic [W-1:0]  ea_val,
    input  logic [W-1:0]  ba_val,
    output logic [W-1:0]  npc,
    output logic          link_req,
    output logic [IW-1:0] link_addr,
    output logic [W-1:0]  link_data,
    output logic          restore_req
);

    localparam int            OFS_W   = 16;
    localparam int            REGION  = 4;
    localparam logic [IW-1:0] RA_IDX  = IW'(LINK_IDX);

    logic [W-1:0] seq_pc;
    logic [W-1:0] br_pc;
    logic [W-1:0] abs_pc;

    assign seq_pc    = pc + W'(4);
    assign br_pc     = seq_pc + {{(W-OFS_W){imm26[OFS_W-1]}}, imm26[OFS_W-1:2], 2'b00};
    assign abs_pc    = {pc[W-1:W-REGION], imm26, 2'b00};
    assign link_data = seq_pc;

    always_comb begin
        npc         = seq_pc;
        link_req    = 1'b0;
        link_addr   = RA_IDX;
        restore_req = 1'b0;
        unique case (flow)
            FL_SEQ:    npc = seq_pc;
            FL_BR:     npc = br_pc;
            FL_BCOND:  npc = taken ? br_pc : seq_pc;
            FL_JABS:   npc = abs_pc;
            FL_CALL:   begin npc = abs_pc; link_req = 1'b1; end
            FL_JREG:   npc = opnd_a;
            FL_CALLR:  begin npc = opnd_a; link_req = 1'b1; end
            FL_RET:    npc = ra_val;
            FL_NEXTPC: begin
                link_addr = c_idx;
                link_req  = (c_idx != '0);
            end
            FL_ERET:   begin npc = ea_val; restore_req = 1'b1; end
            FL_BRET:   begin npc = ba_val; restore_req = 1'b1; end
            default:   npc = seq_pc;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [31:0]      instr,
    input  logic [31:0]      opnd_a,
    input  logic [31:0]      opnd_b,
    input  logic [31:0]      ra_val,
    input  logic [31:0]      ea_val,
    input  logic [31:0]      ba_val,
    input  logic             redirect_valid,
    input  logic [31:0]      redirect_pc,
    output logic [31:0]      pc,
    output logic             link_we,
    output logic [4:0]       link_addr,
    output logic [31:0]      link_data,
    output logic             status_restore
);

    localparam int W = XLEN;

    flow_e        flow;
    cmp_e         cond;
    logic         taken;
    logic [W-1:0] tgt_pc;
    logic [W-1:0] pc_d;
    logic         link_req;
    logic         restore_req;
    logic         advance;

    npc_decode u_dec (
        .op    (instr[5:0]),
        .xcode (instr[16:11]),
        .flow  (flow),
        .cond  (cond)
    );

    npc_compare #(.W(W)) u_cmp (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .cond   (cond),
        .taken  (taken)
    );

    npc_target #(.W(W), .IW(IDX_W), .LINK_IDX(31)) u_tgt (
        .flow        (flow),
        .taken       (taken),
        .pc          (pc),
        .imm26       (instr[31:6]),
        .c_idx       (instr[21:17]),
        .opnd_a      (opnd_a),
        .ra_val      (ra_val),
        .ea_val      (ea_val),
        .ba_val      (ba_val),
        .npc         (tgt_pc),
        .link_req    (link_req),
        .link_addr   (link_addr),
        .link_data   (link_data),
        .restore_req (restore_req)
    );

    // state register: RESET, REDIRECT, ADVANCE or HOLD
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_PC;
        else        pc <= pc_d;
    end

    // next-state and outputs
    always_comb begin
        advance        = instr_valid && !redirect_valid;
        pc_d           = pc;
        if (redirect_valid) pc_d = redirect_pc;
        else if (advance)   pc_d = tgt_pc;
        link_we        = advance && link_req;
        status_restore = advance && restore_req;
    end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [5:0]  instr_op,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc,
    input logic [31:0] pc,
    input logic        link_we,
    input logic [4:0]  link_addr,
    input logic [31:0] link_data,
    input logic        status_restore
);

    a_r1_reset_pc: assert property (@(posedge clk) !rst_n |=> pc == RESET_PC);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !redirect_valid) |=> pc == $past(pc));

    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !redirect_valid && instr_op == 6'h04) |=> pc == $past(pc) + 32'd4);

    a_r5_call_link: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !redirect_valid && instr_op == 6'h00)
        |-> (link_we && link_addr == 5'd31 && link_data == pc + 32'd4));

    a_r7_no_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> link_addr != 5'd0);

    a_r8_restore_alone: assert property (@(posedge clk) disable iff (!rst_n)
        status_restore |-> !link_we);

    a_r9_redirect_load: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> pc == $past(redirect_pc));

    a_r9_redirect_squash: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (!link_we && !status_restore));

endmodule

bind npc_unit npc_unit_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_valid    (instr_valid),
    .instr_op       (instr[5:0]),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .pc             (pc),
    .link_we        (link_we),
    .link_addr      (link_addr),
    .link_data      (link_data),
    .status_restore (status_restore)
);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;

    localparam logic [31:0] RST_PC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [31:0] ra_val = '0, ea_val = '0, ba_val = '0;
    logic        redirect_valid = 1'b0;
    logic [31:0] redirect_pc = '0;
    logic [31:0] pc;
    logic        link_we;
    logic [4:0]  link_addr;
    logic [31:0] link_data;
    logic        status_restore;

    int total = 0;
    int bad = 0;
    logic [31:0] mdl_pc;
    bit done = 0;

    always #5 clk = ~clk;

    npc_unit #(.RESET_PC(RST_PC)) u0 (.*);

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] a, logic [4:0] b, logic [15:0] imm);
        return {a, b, imm, op};
    endfunction
    function automatic logic [31:0] enc_r(logic [5:0] xc, logic [4:0] a, logic [4:0] b, logic [4:0] c);
        return {a, b, c, xc, 5'd0, 6'h3A};
    endfunction
    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] imm);
        return {imm, op};
    endfunction

    function automatic string req_of(logic [31:0] ins, logic v, logic rv);
        if (rv) return "R9";
        if (!v) return "R2";
        case (ins[5:0])
            6'h06: return "R3";
            6'h0E, 6'h16, 6'h1E, 6'h26, 6'h2E, 6'h36: return "R4";
            6'h00, 6'h01: return "R5";
            6'h3A: case (ins[16:11])
                6'h0D, 6'h1D, 6'h05: return "R6";
                6'h1C: return "R7";
                6'h01, 6'h09: return "R8";
                default: return "R2";
            endcase
            default: return "R2";
        endcase
    endfunction

    function automatic void model(input logic [31:0] ins, input logic [31:0] p,
            input logic [31:0] a, input logic [31:0] b, input logic [31:0] ra,
            input logic [31:0] ea, input logic [31:0] ba, input logic v,
            input logic rv, input logic [31:0] rpc,
            output logic [31:0] npc, output logic lwe, output logic [4:0] la,
            output logic rs);
        logic [31:0] seq, brt, abt;
        logic        tk;
        seq = p + 32'd4;
        brt = seq + ({{16{ins[21]}}, ins[21:6]} & ~32'h3);
        abt = {p[31:28], ins[31:6], 2'b00};
        npc = v ? seq : p;
        lwe = 1'b0; la = 5'd31; rs = 1'b0;
        if (v) begin
            case (ins[5:0])
                6'h06: npc = brt;
                6'h0E: begin tk = $signed(a) >= $signed(b); npc = tk ? brt : seq; end
                6'h16: begin tk = $signed(a) <  $signed(b); npc = tk ? brt : seq; end
                6'h1E: begin tk = a != b; npc = tk ? brt : seq; end
                6'h26: begin tk = a == b; npc = tk ? brt : seq; end
                6'h2E: begin tk = a >= b; npc = tk ? brt : seq; end
                6'h36: begin tk = a <  b; npc = tk ? brt : seq; end
                6'h01: npc = abt;
                6'h00: begin npc = abt; lwe = 1'b1; end
                6'h3A: case (ins[16:11])
                    6'h0D: npc = a;
                    6'h1D: begin npc = a; lwe = 1'b1; end
                    6'h05: npc = ra;
                    6'h1C: begin la = ins[21:17]; lwe = (ins[21:17] != 0); end
                    6'h01: begin npc = ea; rs = 1'b1; end
                    6'h09: begin npc = ba; rs = 1'b1; end
                    default: ;
                endcase
                default: ;
            endcase
        end
        if (rv) begin npc = rpc; lwe = 1'b0; rs = 1'b0; end
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(logic [31:0] ins, logic v, logic [31:0] a, logic [31:0] b,
                        logic rv, logic [31:0] rpc);
        logic [31:0] e_pc;
        logic        e_we, e_rs;
        logic [4:0]  e_la;
        string       rq;
        @(negedge clk);
        instr = ins; instr_valid = v; opnd_a = a; opnd_b = b;
        redirect_valid = rv; redirect_pc = rpc;
        model(ins, mdl_pc, a, b, ra_val, ea_val, ba_val, v, rv, rpc, e_pc, e_we, e_la, e_rs);
        rq = req_of(ins, v, rv);
        #1;
        chk(rv ? "R9" : "R10", {rq, " link_we"}, 32'(link_we), 32'(e_we));
        if (e_we) begin
            chk("R10", {rq, " link_addr"}, 32'(link_addr), 32'(e_la));
            chk("R10", {rq, " link_data"}, link_data, mdl_pc + 32'd4);
        end
        chk(rv ? "R9" : "R8", {rq, " status_restore"}, 32'(status_restore), 32'(e_rs));
        @(posedge clk);
        #1;
        mdl_pc = e_pc;
        chk(rq, "pc", pc, mdl_pc);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7411));
        ra_val = 32'h0000_2220; ea_val = 32'h0000_3330; ba_val = 32'h0000_4440;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset pc", pc, RST_PC);
        chk("R1", "reset link_we", 32'(link_we), 32'd0);
        chk("R1", "reset status_restore", 32'(status_restore), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        mdl_pc = RST_PC;

        // directed corner cases
        step(enc_i(6'h04, 5'd1, 5'd2, 16'h0010), 1'b0, 0, 0, 1'b0, 0);          // R2 hold
        step(enc_i(6'h04, 5'd1, 5'd2, 16'h0010), 1'b1, 0, 0, 1'b0, 0);          // R2 sequential
        step(enc_i(6'h06, 5'd0, 5'd0, 16'hFFF3), 1'b1, 0, 0, 1'b0, 0);          // R3 negative, low bits set
        step(enc_i(6'h06, 5'd0, 5'd0, 16'h0103), 1'b1, 0, 0, 1'b0, 0);          // R3 positive
        step(enc_i(6'h0E, 5'd1, 5'd2, 16'h0040), 1'b1, 32'h8000_0000, 32'd1, 1'b0, 0); // R4 signed GE not taken
        step(enc_i(6'h2E, 5'd1, 5'd2, 16'h0040), 1'b1, 32'h8000_0000, 32'd1, 1'b0, 0); // R4 unsigned GE taken
        step(enc_i(6'h16, 5'd1, 5'd2, 16'h0040), 1'b1, 32'd5, 32'd5, 1'b0, 0);  // R4 LT equal
        step(enc_i(6'h26, 5'd1, 5'd2, 16'h0040), 1'b1, 32'd5, 32'd5, 1'b0, 0);  // R4 EQ taken
        step(enc_r(6'h0D, 5'd3, 5'd0, 5'd0), 1'b1, 32'hF000_0100, 0, 1'b0, 0);  // R6 jump to top region
        step(enc_j(6'h01, 26'h3FF_FFFF), 1'b1, 0, 0, 1'b0, 0);                  // R5 region kept
        step(enc_j(6'h00, 26'h000_0040), 1'b1, 0, 0, 1'b0, 0);                  // R5 call
        step(enc_r(6'h1C, 5'd0, 5'd0, 5'd0), 1'b1, 0, 0, 1'b0, 0);              // R7 dest zero
        step(enc_r(6'h1C, 5'd0, 5'd0, 5'd9), 1'b1, 0, 0, 1'b0, 0);              // R7 dest 9
        step(enc_r(6'h1D, 5'd4, 5'd0, 5'd0), 1'b1, 32'h0000_5000, 0, 1'b0, 0);  // R6 callr
        step(enc_r(6'h05, 5'd31, 5'd0, 5'd0), 1'b1, 0, 0, 1'b0, 0);             // R6 ret
        step(enc_r(6'h01, 5'd29, 5'd0, 5'd0), 1'b1, 0, 0, 1'b0, 0);             // R8 eret
        step(enc_r(6'h09, 5'd30, 5'd0, 5'd0), 1'b1, 0, 0, 1'b0, 0);             // R8 bret
        step(enc_j(6'h00, 26'h000_0080), 1'b1, 0, 0, 1'b1, 32'h0000_0020);      // R9 squashes call
        step(enc_r(6'h01, 5'd29, 5'd0, 5'd0), 1'b1, 0, 0, 1'b1, 32'h0000_0040); // R9 squashes eret
        step(enc_i(6'h04, 5'd0, 5'd0, 16'h0), 1'b0, 0, 0, 1'b1, 32'h0000_0060); // R9 without valid

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] ins, a, b, rpc;
            logic [4:0]  fa, fb, fc;
            logic        v, rv;
            int          k;
            fa = 5'($urandom); fb = 5'($urandom); fc = 5'($urandom_range(0, 3) == 0 ? 0 : $urandom);
            k  = $urandom_range(0, 15);
            case (k)
                0:  ins = enc_j(6'h00, 26'($urandom));
                1:  ins = enc_j(6'h01, 26'($urandom));
                2:  ins = enc_i(6'h06, fa, fb, 16'($urandom));
                3:  ins = enc_i(6'h0E, fa, fb, 16'($urandom));
                4:  ins = enc_i(6'h16, fa, fb, 16'($urandom));
                5:  ins = enc_i(6'h1E, fa, fb, 16'($urandom));
                6:  ins = enc_i(6'h26, fa, fb, 16'($urandom));
                7:  ins = enc_i(6'h2E, fa, fb, 16'($urandom));
                8:  ins = enc_i(6'h36, fa, fb, 16'($urandom));
                9:  ins = enc_r(6'h01, fa, fb, fc);
                10: ins = enc_r(6'h05, fa, fb, fc);
                11: ins = enc_r(6'h09, fa, fb, fc);
                12: ins = enc_r(6'h0D, fa, fb, fc);
                13: ins = enc_r(6'h1C, fa, fb, fc);
                14: ins = enc_r(6'h1D, fa, fb, fc);
                default: ins = enc_i(6'h04, fa, fb, 16'($urandom));
            endcase
            a = $urandom;
            case ($urandom_range(0, 3))
                0: b = a;
                1: b = a ^ 32'h8000_0000;
                default: b = $urandom;
            endcase
            v   = ($urandom_range(0, 15) != 0);
            rv  = ($urandom_range(0, 15) == 0);
            rpc = $urandom & ~32'h3;
            ra_val = $urandom; ea_val = $urandom; ba_val = $urandom;
            step(ins, v, a, b, rv, rpc);
        end

        // R1 reset again mid-run
        @(negedge clk); rst_n = 1'b0; instr_valid = 1'b0; redirect_valid = 1'b0;
        @(posedge clk); #1;
        chk("R1", "re-reset pc", pc, RST_PC);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule